// File: doc/BRIEF.md
# Serial Register Bus Master

This block drives a four-wire serial register bus towards a neighbouring FPGA from the host side. The bus has an active-low select (`bus_sel_n`), a bit clock (`bus_sclk`), a master-to-slave data line (`bus_mosi`) and a slave-to-master data line (`bus_miso`). Commands arrive as a valid/ready byte stream. Results leave on a second valid/ready byte stream.

The first byte of a command picks the operation. `8'hC1` is a word write and `8'hC2` is a write-read. The second byte is a count N, which must be 1 to 31. For a word write, N 16-bit words follow, each sent high byte first. Each word goes out as one 16-bit bus frame. For a write-read, N address bytes follow. Each one starts a frame that sends the byte with its top bit forced to 1 as a read marker, then clocks in an 8-bit reply. The replies are held inside the block until the whole command has run, and are then returned in order.

The bit period is `BIT_CYC` system clocks, split into a low half and a high half. Between frames the clock rests low and select stays high for at least one bit period.

Top module: `srm_master`

## Requirements
- R1: After reset, `bus_sel_n` is 1, `bus_sclk` is 0, `bus_mosi` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: A word write sends each accepted 16-bit word MSB first in one frame of 16 rising clock edges. `bus_mosi` holds the bit for the whole low half and high half around its rising edge.
- R3: Select stays low for the whole of each frame. The clock is low whenever select is high. Select stays high for at least `BIT_CYC` cycles between two frames.
- R4: A write word whose bit 15 is 1 is consumed from the input stream but produces no frame. The remaining words of the command are still sent.
- R5: A write-read frame sends 8 bits, MSB first. The first bit is always 1 and the next 7 are bits 6..0 of the supplied byte. Eight more clocks follow, with `bus_mosi` held at 0.
- R6: Each reply bit is taken from `bus_miso` in the system cycle right after a falling edge of `bus_sclk`. The first bit taken becomes the MSB of the reply.
- R7: `out_valid` stays low until all N frames of a write-read command have ended. The N replies are then returned in the order of their frames, and no extra byte follows.
- R8: A count byte of 0 or above 31 ends the command with no bus activity. The next input byte is taken as a new opcode.
- R9: An opcode byte other than `8'hC1` or `8'hC2` is consumed and causes no bus activity. The next byte is taken as an opcode.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R11: `in_ready` is 0 whenever select is low and while replies are being returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Command byte accepted when high with `in_valid` |
| in_data | input | 8 | Command byte |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Reply byte taken when high with `out_valid` |
| out_data | output | 8 | Reply byte |
| bus_sel_n | output | 1 | Active-low bus select |
| bus_sclk | output | 1 | Bus bit clock, idles low |
| bus_mosi | output | 1 | Serial data towards the slave |
| bus_miso | input | 1 | Serial data from the slave |

## Verification
The write path is swept with a walking single one and a walking single zero over the 15 legal bit positions. A misordered or stuck bit on the data line therefore shows up at its own position. A mixed list with bit 15 set in leading, middle and trailing words shows whether rejected words are dropped without disturbing their neighbours. The write-read path covers every 7-bit address value, alternately supplied with and without the top bit set, against a slave model whose reply depends on the address. This separates forced-read-marker errors, reply bit-order errors and buffer ordering errors. Reply backpressure, zero and oversize counts, and an unknown opcode followed by a valid command check flow control and command resynchronisation.

// File: rtl/srm_pkg.sv
package srm_pkg;

    localparam logic [7:0] OP_WRITE = 8'hC1;
    localparam logic [7:0] OP_XACT  = 8'hC2;

    localparam int FRAME_BITS = 16;
    localparam int SEND_BITS  = 8;
    localparam int REPLY_BITS = FRAME_BITS - SEND_BITS;

    typedef enum logic [2:0] {
        SQ_OP,
        SQ_CNT,
        SQ_HI,
        SQ_LO,
        SQ_ADDR,
        SQ_XFER,
        SQ_DRAIN
    } seq_state_t;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_LOW,
        EN_HIGH,
        EN_TAIL,
        EN_GAP
    } eng_state_t;

    typedef struct packed {
        logic [FRAME_BITS-1:0] word;
        logic                  rd;
    } frame_req_t;

    function automatic logic [FRAME_BITS-1:0] read_frame(input logic [6:0] addr);
        return {1'b1, addr, {REPLY_BITS{1'b0}}};
    endfunction

    function automatic logic count_ok(input logic [7:0] n, input int unsigned max_n);
        return (n != 8'd0) && (32'(n) <= max_n);
    endfunction

endpackage

// File: rtl/srm_shifter.sv
module srm_shifter
    import srm_pkg::*;
#(
    parameter int BIT_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  frame_req_t req,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sel_n,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int HALF = BIT_CYC / 2;
    localparam int TW   = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
    localparam logic [TW-1:0] HALF_END = TW'(HALF - 1);
    localparam logic [TW-1:0] GAP_END  = TW'(BIT_CYC - 1);
    localparam logic [3:0]    LAST_IDX = 4'(FRAME_BITS - 1);
    localparam logic [3:0]    RX_FIRST = 4'(SEND_BITS);

    eng_state_t            st;
    logic [TW-1:0]         tmr;
    logic [3:0]            idx;
    logic [FRAME_BITS-1:0] sh;
    logic                  rd;
    logic                  samp;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= EN_IDLE;
            tmr     <= '0;
            idx     <= '0;
            sh      <= '0;
            rd      <= 1'b0;
            samp    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
            sel_n   <= 1'b1;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
        end else begin
            done <= 1'b0;
            samp <= 1'b0;
            if (samp) begin
                rx_byte <= {rx_byte[6:0], miso};
            end
            case (st)
                EN_IDLE: begin
                    if (start) begin
                        sel_n <= 1'b0;
                        mosi  <= req.word[FRAME_BITS-1];
                        sh    <= {req.word[FRAME_BITS-2:0], 1'b0};
                        rd    <= req.rd;
                        tmr   <= '0;
                        idx   <= '0;
                        st    <= EN_LOW;
                    end
                end
                EN_LOW: begin
                    if (tmr == HALF_END) begin
                        tmr  <= '0;
                        sclk <= 1'b1;
                        st   <= EN_HIGH;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                EN_HIGH: begin
                    if (tmr == HALF_END) begin
                        tmr  <= '0;
                        sclk <= 1'b0;
                        samp <= rd && (idx >= RX_FIRST);
                        if (idx == LAST_IDX) begin
                            st <= EN_TAIL;
                        end else begin
                            idx  <= idx + 1'b1;
                            mosi <= sh[FRAME_BITS-1];
                            sh   <= {sh[FRAME_BITS-2:0], 1'b0};
                            st   <= EN_LOW;
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                EN_TAIL: begin
                    if (tmr == HALF_END) begin
                        tmr   <= '0;
                        sel_n <= 1'b1;
                        mosi  <= 1'b0;
                        st    <= EN_GAP;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                EN_GAP: begin
                    if (tmr == GAP_END) begin
                        tmr  <= '0;
                        done <= 1'b1;
                        st   <= EN_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srm_reply_buf.sv
module srm_reply_buf #(
    parameter int DEPTH = 31,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rp;
    logic [CW-1:0]    cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty = (cnt == '0);
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                wp <= bump(wp);
            end
            if (pop && !empty) begin
                rp <= bump(rp);
            end
            case ({push, pop && !empty})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/srm_sequencer.sv
module srm_sequencer
    import srm_pkg::*;
#(
    parameter int MAX_N = 31
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       eng_start,
    output frame_req_t eng_req,
    input  logic       eng_done,
    output logic       buf_push,
    output logic       buf_pop,
    input  logic       buf_empty
);
    localparam int CW = $clog2(MAX_N + 1);
    localparam logic [CW-1:0] ONE = CW'(1);

    seq_state_t    st;
    logic          wr_mode;
    logic [CW-1:0] remain;
    logic [7:0]    hi_byte;
    logic          take;
    logic          last;

    assign in_ready = (st != SQ_XFER) && (st != SQ_DRAIN);
    assign take     = in_valid && in_ready;
    assign last     = (remain == ONE);

    assign eng_start = take && (((st == SQ_LO) && !hi_byte[7]) || (st == SQ_ADDR));

    always_comb begin
        eng_req.rd   = (st == SQ_ADDR);
        eng_req.word = (st == SQ_ADDR) ? read_frame(in_data[6:0]) : {hi_byte, in_data};
    end

    assign buf_push  = (st == SQ_XFER) && eng_done && !wr_mode;
    assign out_valid = (st == SQ_DRAIN) && !buf_empty;
    assign buf_pop   = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_OP;
            wr_mode <= 1'b0;
            remain  <= '0;
            hi_byte <= '0;
        end else begin
            case (st)
                SQ_OP: begin
                    if (take) begin
                        if (in_data == OP_WRITE) begin
                            wr_mode <= 1'b1;
                            st      <= SQ_CNT;
                        end else if (in_data == OP_XACT) begin
                            wr_mode <= 1'b0;
                            st      <= SQ_CNT;
                        end
                    end
                end
                SQ_CNT: begin
                    if (take) begin
                        if (count_ok(in_data, MAX_N)) begin
                            remain <= in_data[CW-1:0];
                            st     <= wr_mode ? SQ_HI : SQ_ADDR;
                        end else begin
                            st <= SQ_OP;
                        end
                    end
                end
                SQ_HI: begin
                    if (take) begin
                        hi_byte <= in_data;
                        st      <= SQ_LO;
                    end
                end
                SQ_LO: begin
                    if (take) begin
                        if (hi_byte[7]) begin
                            remain <= remain - 1'b1;
                            st     <= last ? SQ_OP : SQ_HI;
                        end else begin
                            st <= SQ_XFER;
                        end
                    end
                end
                SQ_ADDR: begin
                    if (take) begin
                        st <= SQ_XFER;
                    end
                end
                SQ_XFER: begin
                    if (eng_done) begin
                        remain <= remain - 1'b1;
                        if (last) begin
                            st <= wr_mode ? SQ_OP : SQ_DRAIN;
                        end else begin
                            st <= wr_mode ? SQ_HI : SQ_ADDR;
                        end
                    end
                end
                SQ_DRAIN: begin
                    if (buf_empty) begin
                        st <= SQ_OP;
                    end
                end
                default: st <= SQ_OP;
            endcase
        end
    end

endmodule

// File: rtl/srm_master.sv
module srm_master
    import srm_pkg::*;
#(
    parameter int BIT_CYC = 8,
    parameter int MAX_N   = 31
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       bus_sel_n,
    output logic       bus_sclk,
    output logic       bus_mosi,
    input  logic       bus_miso
);
    frame_req_t eng_req;
    logic       eng_start;
    logic       eng_done;
    logic [7:0] rx_byte;
    logic       buf_push;
    logic       buf_pop;
    logic       buf_empty;

    srm_sequencer #(
        .MAX_N (MAX_N)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .eng_start (eng_start),
        .eng_req   (eng_req),
        .eng_done  (eng_done),
        .buf_push  (buf_push),
        .buf_pop   (buf_pop),
        .buf_empty (buf_empty)
    );

    srm_shifter #(
        .BIT_CYC (BIT_CYC)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .req     (eng_req),
        .done    (eng_done),
        .rx_byte (rx_byte),
        .sel_n   (bus_sel_n),
        .sclk    (bus_sclk),
        .mosi    (bus_mosi),
        .miso    (bus_miso)
    );

    srm_reply_buf #(
        .DEPTH (MAX_N),
        .WIDTH (8)
    ) u_buf (
        .clk   (clk),
        .rst   (rst),
        .push  (buf_push),
        .din   (rx_byte),
        .pop   (buf_pop),
        .dout  (out_data),
        .empty (buf_empty)
    );

endmodule

// File: rtl/srm_master_chk.sv
module srm_master_chk #(
    parameter int BIT_CYC = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       bus_sel_n,
    input logic       bus_sclk,
    input logic       bus_mosi
);
    localparam int GW = $clog2(BIT_CYC + 2);
    localparam logic [GW-1:0] GAP_MIN = GW'(BIT_CYC);

    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= GAP_MIN;
        end else if (!bus_sel_n) begin
            gap <= '0;
        end else if (gap < GAP_MIN) begin
            gap <= gap + 1'b1;
        end
    end

    p_idle_clk_low_r3: assert property (@(posedge clk) disable iff (rst)
        bus_sel_n |-> !bus_sclk);

    p_sel_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_sel_n) |-> (gap >= GAP_MIN));

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sclk && $past(bus_sclk)) |-> $stable(bus_mosi));

    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_busy_no_input_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_sel_n |-> !in_ready);

    p_reply_after_bus_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> bus_sel_n);

endmodule

bind srm_master srm_master_chk #(
    .BIT_CYC (BIT_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .bus_sel_n (bus_sel_n),
    .bus_sclk  (bus_sclk),
    .bus_mosi  (bus_mosi)
);

// File: tb/tb_srm_master.sv
module tb_srm_master;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CYC    = 4;
    localparam int MAX_N      = 31;
    localparam logic [7:0] OP_WRITE = 8'hC1;
    localparam logic [7:0] OP_XACT  = 8'hC2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       bus_sel_n;
    logic       bus_sclk;
    logic       bus_mosi;
    logic       bus_miso = 1'b0;

    srm_master #(.BIT_CYC(BIT_CYC), .MAX_N(MAX_N)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .bus_sel_n(bus_sel_n), .bus_sclk(bus_sclk), .bus_mosi(bus_mosi),
        .bus_miso(bus_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reply_of(input logic [7:0] a);
        return (a * 8'd7) ^ 8'h3C;
    endfunction

    // slave model and frame recorder
    logic [15:0] shf = '0;
    int          rises = 0;
    bit          open = 0;
    logic [7:0]  addr_hold = '0;
    logic [15:0] fr_data [64];
    int          fr_rises [64];
    int          fr_n = 0;

    always @(negedge bus_sel_n) begin
        open  = 1;
        rises = 0;
        shf   = '0;
    end

    always @(posedge bus_sclk) begin
        if (open) begin
            logic [7:0] r;
            shf = {shf[14:0], bus_mosi};
            rises++;
            if (rises == 8) addr_hold = shf[7:0];
            if (rises >= 9 && rises <= 16) begin
                r = reply_of(addr_hold);
                bus_miso = r[7 - (rises - 9)];
            end
        end
    end

    always @(posedge bus_sel_n) begin
        if (open) begin
            open = 0;
            if (fr_n < 64) begin
                fr_data[fr_n]  = shf;
                fr_rises[fr_n] = rises;
            end
            fr_n++;
            bus_miso = 1'b0;
        end
    end

    // port monitors sampled on the falling system clock
    int gap_cnt = BIT_CYC;
    int gap_viol = 0;
    int busy_viol = 0;
    always @(negedge clk) begin
        if (rst) begin
            gap_cnt = BIT_CYC;
        end else begin
            if (!bus_sel_n && in_ready) busy_viol++;
            if (bus_sel_n) gap_cnt++;
            else begin
                if (gap_cnt != 0 && gap_cnt < BIT_CYC) gap_viol++;
                gap_cnt = 0;
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready || !bus_sel_n) @(negedge clk);
        repeat (BIT_CYC * 3) @(negedge clk);
    endtask

    logic [15:0] wbuf [64];
    logic [7:0]  abuf [64];

    task automatic run_write(input int n, input string req);
        int k;
        fr_n = 0;
        send_byte(OP_WRITE);
        send_byte(8'(n));
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i][15:8]);
            send_byte(wbuf[i][7:0]);
        end
        wait_idle();
        k = 0;
        for (int i = 0; i < n; i++) begin
            if (!wbuf[i][15]) begin
                chk(k < fr_n && fr_data[k] == wbuf[i], req, int'(fr_data[k]), int'(wbuf[i]));
                chk(fr_rises[k] == 16, "R2 rise count", fr_rises[k], 16);
                k++;
            end
        end
        chk(fr_n == k, {req, " frame count"}, fr_n, k);
    endtask

    task automatic run_xact(input int n, input int ready_mode);
        int got = 0;
        int guard = 0;
        bit hold_prev = 0;
        logic [7:0] data_prev = '0;
        logic [7:0] rbuf [64];
        fr_n = 0;
        send_byte(OP_XACT);
        send_byte(8'(n));
        for (int i = 0; i < n; i++) send_byte(abuf[i]);
        while (got < n && guard < 20000) begin
            @(negedge clk);
            guard++;
            out_ready = (ready_mode == 0) ? 1'b1 : ((guard % 3) != 1);
            if (hold_prev)
                chk(out_valid && out_data == data_prev, "R10 hold", int'(out_data), int'(data_prev));
            hold_prev = out_valid && !out_ready;
            data_prev = out_data;
            if (out_valid && out_ready) begin
                if (got == 0) chk(fr_n == n, "R7 replies after all frames", fr_n, n);
                rbuf[got] = out_data;
                got++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(got == n, "R7 reply count", got, n);
        wait_idle();
        chk(!out_valid, "R7 no extra reply", int'(out_valid), 0);
        chk(fr_n == n, "R5 frame count", fr_n, n);
        for (int i = 0; i < n && i < got; i++) begin
            logic [7:0] sent;
            sent = {1'b1, abuf[i][6:0]};
            chk(fr_data[i] == {sent, 8'h00}, "R5 read frame", int'(fr_data[i]), int'({sent, 8'h00}));
            chk(rbuf[i] == reply_of(sent), "R6 R7 reply", int'(rbuf[i]), int'(reply_of(sent)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(bus_sel_n == 1'b1, "R1 sel", int'(bus_sel_n), 1);
        chk(bus_sclk == 1'b0, "R1 sclk", int'(bus_sclk), 0);
        chk(bus_mosi == 1'b0, "R1 mosi", int'(bus_mosi), 0);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R2: walking one then walking zero over the 15 legal bits
        for (int i = 0; i < 30; i++)
            wbuf[i] = (i < 15) ? (16'h1 << i) : (~(16'h1 << (i - 15)) & 16'h7FFF);
        run_write(30, "R2 walking word");

        // R4: words with bit 15 set are dropped
        wbuf[0] = 16'h8000; wbuf[1] = 16'h1234; wbuf[2] = 16'hFFFF;
        wbuf[3] = 16'h7FFF; wbuf[4] = 16'h8001; wbuf[5] = 16'h0F0F;
        wbuf[6] = 16'hC0DE;
        run_write(7, "R4 reject bit15");

        // R5 R6 R7: every 7-bit address, top bit supplied both ways
        for (int c = 0; c < 5; c++) begin
            for (int i = 0; i < 26; i++) begin
                logic [7:0] a;
                a = 8'((c * 26 + i) & 127);
                abuf[i] = (i % 2 == 1) ? (a | 8'h80) : a;
            end
            run_xact(26, c % 2);
        end
        abuf[0] = 8'h2A;
        run_xact(1, 1);
        for (int i = 0; i < MAX_N; i++) abuf[i] = 8'(i * 5 + 3);
        run_xact(MAX_N, 1);

        // R8: zero count and oversize count abort
        fr_n = 0;
        send_byte(OP_WRITE); send_byte(8'd0);
        send_byte(OP_WRITE); send_byte(8'd1); send_byte(8'h12); send_byte(8'h34);
        wait_idle();
        chk(fr_n == 1 && fr_data[0] == 16'h1234, "R8 zero count", fr_n, 1);
        fr_n = 0;
        send_byte(OP_XACT); send_byte(8'd32);
        send_byte(OP_WRITE); send_byte(8'd1); send_byte(8'h05); send_byte(8'h6A);
        wait_idle();
        chk(fr_n == 1 && fr_data[0] == 16'h056A, "R8 oversize count", fr_n, 1);
        chk(!out_valid, "R8 no reply", int'(out_valid), 0);

        // R9: unknown opcode bytes are skipped
        fr_n = 0;
        send_byte(8'h55); send_byte(8'h00); send_byte(8'hC3);
        wait_idle();
        chk(fr_n == 0, "R9 no activity", fr_n, 0);
        send_byte(OP_WRITE); send_byte(8'd1); send_byte(8'h0A); send_byte(8'hBC);
        wait_idle();
        chk(fr_n == 1 && fr_data[0] == 16'h0ABC, "R9 resync", int'(fr_data[0]), 16'h0ABC);

        chk(gap_viol == 0, "R3 select gap", gap_viol, 0);
        chk(busy_viol == 0, "R11 in_ready busy", busy_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule